// File: doc/BRIEF.md
# SCL Clock Divider Generator

This block produces the serial clock timing for a two-wire bus master. The peripheral clock first passes through a small pre-divider (divide by 1 to 4) that yields an internal tick. The SCL period is then counted in internal ticks. Its length is a fixed base of 20 ticks, plus 8 ticks for each step of a 6-bit gap setting, plus a fixed compensation count (`ROUND_TICKS`). The compensation count covers pad fall time, pad rise time and internal delay, rounded up to whole ticks.

The byte engine that owns the bus writes an 8-bit divider word, sets `enable` and pulses `startReq` while the generator is idle. The generator then drives SCL low for the first half of each period. In the middle of that low half it emits `shiftStb` so that the engine can update SDA. It then releases SCL and waits until the line is seen high, which allows for slow rise and for clock stretching by a target. It emits `sampleStb` at that rising point and counts the high half. Periods repeat while `enable` stays set. When `enable` is cleared, the current period finishes and the block goes idle. The divider word is taken only while the block is idle.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset the block is idle: `sclLow`, `sampleStb` and `shiftStb` are all 0.
- R2: The divider word packs the pre-divide field `p` in bits 1:0 and the gap field `g` in bits 7:2. One internal tick lasts `p+1` clock cycles.
- R3: The period is `P = 20 + 8*g + ROUND_TICKS` ticks (default `ROUND_TICKS` = 5). `sclLow` stays 1 for exactly `floor(P/2)*(p+1)` consecutive cycles in every period.
- R4: Counting from the cycle in which `sampleStb` is 1, SCL stays released for exactly `(P - floor(P/2))*(p+1)` cycles before the next low phase starts.
- R5: `shiftStb` pulses exactly once per low phase and never outside it. The pulse comes `floor(floor(P/2)/2)*(p+1) - 1` cycles after the first cycle of the low phase.
- R6: After SCL is released, the high count does not start until `sclIn` is seen high. `sampleStb` is a one-cycle pulse that comes `k+1` cycles after release when the line is held low for `k` edges (k = 0 for a free line).
- R7: Changes to `divCfg` while a burst is running have no effect on any period of that burst.
- R8: When `enable` is cleared, the running period completes and `sclLow` then stays 0 with no further periods.
- R9: A burst starts only on a cycle in which `enable` and `startReq` are both 1. `startReq` without `enable`, or `enable` without `startReq`, leaves SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divCfg | input | GAP_W+PRE_W | Divider word: gap field in bits 7:2, pre-divide field in bits 1:0 |
| enable | input | 1 | Keeps periods running; when cleared, the block stops at the end of the current period |
| startReq | input | 1 | Starts a burst from idle (valid only when `enable` is set) |
| sclIn | input | 1 | Sensed level of the SCL line |
| sclLow | output | 1 | 1 = pull SCL low, 0 = release it |
| sampleStb | output | 1 | One-cycle pulse at the SCL rising point |
| shiftStb | output | 1 | One-cycle pulse in the middle of the low phase, used for SDA updates |

## Verification
The bench covers the extremes of both fields: gap 0 with no pre-divide, which gives the shortest period, and gap 63 with a divide by 4, which gives the longest. A design that swapped the two fields, or that miscounted the pre-divider, would produce low and high widths that do not match the computed values. A stretched line tests that the high count waits for the sensed level; a generator that runs the high phase open-loop would pulse `sampleStb` too early and shorten the released time. The bench also changes `divCfg` mid-burst, which catches a design that reloads the divider word while it runs. It then checks for a clean stop after `enable` falls and for the start gating, which catch a generator that keeps running or starts on a single control input.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  localparam int BASE_TICKS = 20;
  localparam int GAP_STEP_LOG = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAITHI,
    ST_HIGH
  } sclState_e;

  typedef struct packed {
    logic loadCfg;
    logic clrCnt;
    logic runLow;
    logic runHigh;
  } sclCtl_t;

endpackage

// File: rtl/scl_datapath.sv
module scl_datapath
  import sclgen_pkg::*;
#(
  parameter int GAP_W       = 6,
  parameter int PRE_W       = 2,
  parameter int ROUND_TICKS = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [GAP_W+PRE_W-1:0] divCfg,
  input  sclCtl_t                ctl,
  output logic                   phaseEnd,
  output logic                   shiftHit
);

  localparam int CFG_W   = GAP_W + PRE_W;
  localparam int MAX_PER = BASE_TICKS + ((2**GAP_W - 1) << GAP_STEP_LOG) + ROUND_TICKS;
  localparam int CNT_W   = $clog2(MAX_PER + 1);

  logic [CFG_W-1:0] cfgQ;
  logic [PRE_W-1:0] preSel;
  logic [GAP_W-1:0] gapSel;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] periodTicks;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] highLen;
  logic [CNT_W-1:0] midIdx;
  logic [CNT_W-1:0] curLen;
  logic             counting;
  logic             tick;

  // divider word is captured only while the controller reports idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfgQ <= '0;
    else if (ctl.loadCfg) cfgQ <= divCfg;
  end

  assign preSel = cfgQ[PRE_W-1:0];
  assign gapSel = cfgQ[CFG_W-1:PRE_W];

  always_comb begin
    periodTicks = CNT_W'(BASE_TICKS) + (CNT_W'(gapSel) << GAP_STEP_LOG) + CNT_W'(ROUND_TICKS);
    lowLen      = periodTicks >> 1;
    highLen     = periodTicks - lowLen;
    midIdx      = (lowLen >> 1) - CNT_W'(1);
    curLen      = ctl.runLow ? lowLen : highLen;
  end

  assign counting = ctl.runLow | ctl.runHigh;
  assign tick     = counting && (preCnt == preSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           preCnt <= '0;
    else if (ctl.clrCnt) preCnt <= '0;
    else if (counting)   preCnt <= (preCnt == preSel) ? '0 : preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           phaseCnt <= '0;
    else if (ctl.clrCnt) phaseCnt <= '0;
    else if (tick)       phaseCnt <= (phaseCnt == curLen - CNT_W'(1)) ? '0 : phaseCnt + CNT_W'(1);
  end

  assign phaseEnd = tick && (phaseCnt == curLen - CNT_W'(1));
  assign shiftHit = tick && ctl.runLow && (phaseCnt == midIdx);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.runLow || ctl.runHigh) |-> $stable(cfgQ));

  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    counting |-> (phaseCnt < curLen));

  p_shift_not_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    shiftHit |-> !phaseEnd);

endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import sclgen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    startReq,
  input  logic    sclIn,
  input  logic    phaseEnd,
  input  logic    shiftHit,
  output sclCtl_t ctl,
  output logic    sclLow,
  output logic    sampleStb,
  output logic    shiftStb
);

  sclState_e state;
  sclState_e nextState;
  logic      sampleQ;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        ctl.loadCfg = 1'b1;
        ctl.clrCnt  = 1'b1;
        if (enable && startReq) nextState = ST_LOW;
      end
      ST_LOW: begin
        ctl.runLow = 1'b1;
        if (phaseEnd) nextState = ST_WAITHI;
      end
      ST_WAITHI: begin
        ctl.clrCnt = 1'b1;
        if (sclIn) nextState = ST_HIGH;
      end
      ST_HIGH: begin
        ctl.runHigh = 1'b1;
        if (phaseEnd) nextState = enable ? ST_LOW : ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sampleQ <= 1'b0;
    end else begin
      state   <= nextState;
      sampleQ <= (state == ST_WAITHI) && sclIn;
    end
  end

  assign sclLow    = (state == ST_LOW);
  assign sampleStb = sampleQ;
  assign shiftStb  = shiftHit;

  p_sample_needs_line_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> $past(sclIn));

  p_idle_no_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !enable) |=> (state == ST_IDLE));

  p_strobe_apart_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && shiftStb));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import sclgen_pkg::*;
#(
  parameter int GAP_W       = 6,
  parameter int PRE_W       = 2,
  parameter int ROUND_TICKS = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [GAP_W+PRE_W-1:0] divCfg,
  input  logic                   enable,
  input  logic                   startReq,
  input  logic                   sclIn,
  output logic                   sclLow,
  output logic                   sampleStb,
  output logic                   shiftStb
);

  sclCtl_t ctl;
  logic    phaseEnd;
  logic    shiftHit;

  scl_datapath #(
    .GAP_W      (GAP_W),
    .PRE_W      (PRE_W),
    .ROUND_TICKS(ROUND_TICKS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .divCfg  (divCfg),
    .ctl     (ctl),
    .phaseEnd(phaseEnd),
    .shiftHit(shiftHit)
  );

  scl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .startReq (startReq),
    .sclIn    (sclIn),
    .phaseEnd (phaseEnd),
    .shiftHit (shiftHit),
    .ctl      (ctl),
    .sclLow   (sclLow),
    .sampleStb(sampleStb),
    .shiftStb (shiftStb)
  );

endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;

  localparam int CLK_PERIOD = 10;
  localparam int ROUND      = 5;

  typedef struct {
    int lowCyc;
    int shiftOff;
    int highCyc;
    bit chkHigh;
    int stretch;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divCfg = '0;
  logic       enable = 1'b0;
  logic       startReq = 1'b0;
  logic       holdLow = 1'b0;
  logic       sclIn;
  logic       sclLow, sampleStb, shiftStb;

  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 0;
  string tagNote = "";
  exp_t  expQ[$];

  assign sclIn = !sclLow && !holdLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_rate_gen #(.GAP_W(6), .PRE_W(2), .ROUND_TICKS(ROUND)) dut (
    .clk(clk), .rstN(rstN), .divCfg(divCfg), .enable(enable),
    .startReq(startReq), .sclIn(sclIn), .sclLow(sclLow),
    .sampleStb(sampleStb), .shiftStb(shiftStb)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, tagNote, act, expv);
    end
  endtask

  function automatic exp_t mkExp(input logic [7:0] cfg, input bit chk, input int k);
    exp_t e;
    int p, g, per, lo, hi;
    p = int'(cfg[1:0]);
    g = int'(cfg[7:2]);
    per = 20 + 8*g + ROUND;
    lo = per / 2;
    hi = per - lo;
    e.lowCyc   = lo * (p + 1);
    e.shiftOff = (lo / 2) * (p + 1) - 1;
    e.highCyc  = hi * (p + 1);
    e.chkHigh  = chk;
    e.stretch  = k;
    return e;
  endfunction

  // driver: pushes expected periods, runs a burst of n periods, checks the stop
  task automatic runBurst(input logic [7:0] cfg, input int n, input int k,
                          input bit changeCfg, input logic [7:0] altCfg);
    exp_t last;
    int rises;
    bit prevLow;
    int bad;
    int win;
    for (int i = 0; i < n; i++) expQ.push_back(mkExp(cfg, i < n-1, k));
    last = mkExp(cfg, 1'b0, k);
    @(negedge clk);
    divCfg = cfg; enable = 1'b1; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (changeCfg) divCfg = altCfg;
    rises = 1; prevLow = sclLow;
    while (rises < n) begin
      @(negedge clk);
      if (sclLow && !prevLow) rises++;
      prevLow = sclLow;
    end
    enable = 1'b0;
    while (sclLow) @(negedge clk);
    win = last.highCyc + k + 1 + 2*last.lowCyc + 10;
    bad = 0;
    for (int c = 0; c < win; c++) begin
      @(negedge clk);
      if (sclLow) bad++;
    end
    check(bad == 0, "R8 no period after enable cleared", bad, 0);
    check(expQ.size() == 0, "R8 all periods observed", expQ.size(), 0);
  endtask

  // monitor: measures each period and compares against the scoreboard
  initial begin
    exp_t cur;
    bit haveCur = 0, inLow = 0, counting = 0;
    int lowCnt = 0, shiftPos = -1, shiftNum = 0, waitCnt = 0, highCnt = 0, holdCnt = 0;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      if (sclLow) begin
        if (!inLow) begin
          if (haveCur && cur.chkHigh) check(highCnt == cur.highCyc, "R4 high width", highCnt, cur.highCyc);
          inLow = 1; lowCnt = 0; shiftPos = -1; shiftNum = 0;
        end
        if (shiftStb) begin
          if (shiftNum == 0) shiftPos = lowCnt;
          shiftNum++;
        end
        lowCnt++;
      end else begin
        if (shiftStb) check(1'b0, "R5 shift outside low", 1, 0);
        if (inLow) begin
          inLow = 0;
          if (expQ.size() == 0) begin
            check(1'b0, "R8 unexpected period", 1, 0);
            cur = '{lowCyc: 0, shiftOff: 0, highCyc: 0, chkHigh: 0, stretch: 0};
          end else begin
            cur = expQ.pop_front();
            check(lowCnt == cur.lowCyc, "R2/R3 low width", lowCnt, cur.lowCyc);
            check(shiftPos == cur.shiftOff, "R5 shift position", shiftPos, cur.shiftOff);
            check(shiftNum == 1, "R5 one shift per low", shiftNum, 1);
          end
          haveCur = 1;
          waitCnt = 0; highCnt = 0; counting = 0;
          holdCnt = cur.stretch;
          holdLow = (holdCnt > 0);
        end else if (holdCnt > 0) begin
          holdCnt--;
          holdLow = (holdCnt > 0);
        end
        if (sampleStb) begin
          if (!counting) check(waitCnt == cur.stretch + 1, "R6 release to sample", waitCnt, cur.stretch + 1);
          counting = 1;
        end
        if (counting) highCnt++;
        else if (haveCur) waitCnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (5) @(negedge clk);
    tagNote = "reset";
    check(sclLow == 1'b0, "R1 sclLow idle", sclLow, 0);
    check(sampleStb == 1'b0, "R1 sampleStb idle", sampleStb, 0);
    check(shiftStb == 1'b0, "R1 shiftStb idle", shiftStb, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    tagNote = "R9 gating";
    divCfg = 8'h00;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    enable = 1'b1;
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (sclLow || sampleStb || shiftStb) bad++;
    end
    check(bad == 0, "R9 no start without both", bad, 0);
    enable = 1'b0;

    tagNote = "g0 p0";
    runBurst(8'h00, 3, 0, 1'b0, 8'h00);
    tagNote = "R7 g3 p2 cfg change";
    runBurst({6'd3, 2'd2}, 2, 0, 1'b1, 8'hFF);
    tagNote = "R6 stretch g1 p1";
    runBurst({6'd1, 2'd1}, 3, 4, 1'b0, 8'h00);
    tagNote = "R2 g63 p3";
    runBurst({6'd63, 2'd3}, 2, 0, 1'b0, 8'h00);
    tagNote = "R2 g10 p1";
    runBurst({6'd10, 2'd1}, 2, 1, 1'b0, 8'h00);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule